// File: doc/BRIEF.md
# Real-Time Counter with Gated Configuration

This block is a wall-clock style event counter that lives in an always-on power domain and is programmed over a narrow 16-bit register bus. A slow timebase arrives as a single-cycle enable strobe, `lclk_en`, in the bus clock domain. A down-counting divider turns these strobes into periodic ticks, and each tick advances a 32-bit counter. A 32-bit compare value, a wrap detector and three event flags feed one level interrupt.

The divider reload, the counter and the compare value cannot be changed by plain writes. Software first opens a configuration window by setting a control bit. Inside the window, writes land in staging registers. Closing the window starts a commit, which is applied on the next slow strobe. Two status bits expose this crossing to software:

- A "commit finished" bit is low while a commit is still waiting for its strobe.
- A "refreshed" bit can be cleared by software. Every slow strobe sets it again, which tells software that a fresh counter value can be read.

A domain reset input puts all of this state back to its power-on values.

Top module: `rtc_counter_core`

## Requirements
- R1: After reset the control-low register (address 0) reads 0x0020, and the control-high register (address 1) reads 0. The divider reload reads 0x8000: address 2 reads 0 and address 3 reads 0x8000. The counter (addresses 4/5) and compare value (addresses 6/7) read 0. The `irq` output is 0. In each pair, the lower address holds the high half.
- R2: The divider counts down one step per `lclk_en` strobe and produces a tick on every reload-th strobe (every strobe when reload is 0 or 1). On each tick the counter increments by one and the tick flag (control-low bit 0) is set.
- R3: Control-low bit 4 opens the configuration window. While it is 1, writes to addresses 2..7 go to staging registers, and reads of those addresses keep returning the live values. Writing bit 4 from 1 to 0 starts a commit. The next strobe copies only the halves written during the window into the live registers. That commit strobe does not advance the divider or the counter. A committed reload restarts the divider.
- R4: Writes to addresses 2..7 while bit 4 is 0 change nothing, and they are not staged for a later commit.
- R5: Control-low bit 5 reads 0 from the write that closes a window until the strobe that applies the commit, and reads 1 otherwise.
- R6: An attempt to set bit 4 while bit 5 reads 0 is ignored.
- R7: Control-low bit 3 is cleared by writing 0 to it, and it is left unchanged by writing 1. Every `lclk_en` strobe sets it, and the strobe wins over a clear in the same cycle.
- R8: Writing 0 to a flag bit (control-low bits 2:0) clears that flag, and writing 1 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R9: The compare flag (control-low bit 1) is set when the counter value after a tick equals the compare value.
- R10: The wrap flag (control-low bit 2) is set on the tick that takes the counter from 0xFFFFFFFF to 0.
- R11: `irq` is the OR over the three flags, each ANDed with its enable (control-high bits 2:0, same order as the flags). `irq` stays high until software clears the flag or the enable.
- R12: The reload value is 20 bits wide. Address 2 keeps only its low 4 bits, and the remaining bits read 0.
- R13: A one-cycle pulse on `dom_rst` returns the following to their R1 values: the counter, compare value, reload, divider, flags, enables, window, commit state and the refreshed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dom_rst | input | 1 | Synchronous domain reset, active high |
| lclk_en | input | 1 | Slow timebase strobe, one bus cycle wide |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on `bus_addr` |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take for granted that once reset is released, every input is 0 or 1, that `bus_addr` only names the eight defined registers, and that `dom_rst` is the only path other than bus writes that clears flags. The stimulus keeps to this by the following means:

- It changes inputs one time unit after a rising edge.
- It pulses `lclk_en` for one cycle, with an idle cycle between pulses.
- It issues one write at a time.
- It waits for the commit-finished bit before opening a new window, except where R6 is being exercised on purpose.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int unsigned BUS_W    = 16;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned NUM_EV   = 3;
    localparam int unsigned NUM_HALF = 6;

    // control-low bit positions above the event flags
    localparam int unsigned CL_SYNC = 3;
    localparam int unsigned CL_CFG  = 4;
    localparam int unsigned CL_DONE = 5;

    // event flag order (also the enable order)
    localparam int unsigned EV_TICK = 0;
    localparam int unsigned EV_CMP  = 1;
    localparam int unsigned EV_WRAP = 2;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTL0 = 3'd0,
        RA_CTL1 = 3'd1,
        RA_DIVH = 3'd2,
        RA_DIVL = 3'd3,
        RA_CNTH = 3'd4,
        RA_CNTL = 3'd5,
        RA_CMPH = 3'd6,
        RA_CMPL = 3'd7
    } reg_addr_e;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int unsigned       DIV_W      = 20,
    parameter logic [DIV_W-1:0]  RST_RELOAD = DIV_W'(32'h8000)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             load,
    input  logic [DIV_W-1:0] reload,
    output logic             tick
);

    function automatic logic [DIV_W-1:0] first_count(input logic [DIV_W-1:0] r);
        return (r == '0) ? '0 : r - 1'b1;
    endfunction

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        tick  = step && (div_q == '0);
        if (load) begin
            div_d = first_count(reload);
        end else if (step) begin
            div_d = tick ? first_count(reload) : div_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= first_count(RST_RELOAD);
        end else if (clr) begin
            div_q <= first_count(RST_RELOAD);
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/rtc_stage.sv
module rtc_stage #(
    parameter int unsigned DW = 16,
    parameter int unsigned NH = 6,
    localparam int unsigned IW = $clog2(NH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [DW-1:0]         wdata,
    input  logic                  apply,
    output logic [NH-1:0][DW-1:0] val,
    output logic [NH-1:0]         pend
);

    for (genvar i = 0; i < NH; i++) begin : g_slot
        logic [DW-1:0] val_d, val_q;
        logic          pend_d, pend_q;

        always_comb begin
            val_d  = val_q;
            pend_d = pend_q;
            if (apply) begin
                pend_d = 1'b0;
            end
            if (wr_en && (wr_idx == IW'(i))) begin
                val_d  = wdata;
                pend_d = 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q  <= '0;
                pend_q <= 1'b0;
            end else if (clr) begin
                val_q  <= '0;
                pend_q <= 1'b0;
            end else begin
                val_q  <= val_d;
                pend_q <= pend_d;
            end
        end

        assign val[i]  = val_q;
        assign pend[i] = pend_q;
    end

endmodule

// File: rtl/rtc_events.sv
module rtc_events #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    input  logic         wr_en,
    input  logic [N-1:0] wmask,
    input  logic [N-1:0] en,
    output logic [N-1:0] flags,
    output logic         irq
);

    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        if (wr_en) begin
            flags_d = flags_d & wmask;
        end
        flags_d = flags_d | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (clr) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;
    assign irq   = |(flags_q & en);

endmodule

// File: rtl/rtc_counter_core.sv
module rtc_counter_core
    import rtc_pkg::*;
#(
    parameter int unsigned      DIV_W      = 20,
    parameter logic [DIV_W-1:0] RST_RELOAD = DIV_W'(32'h8000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dom_rst,
    input  logic              lclk_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);

    localparam int unsigned CNT_W    = 2 * BUS_W;
    localparam int unsigned DIV_HI_W = DIV_W - BUS_W;
    localparam int unsigned IW       = $clog2(NUM_HALF);

    typedef struct packed {
        logic              cfg;
        logic              busy;
        logic              sync;
        logic [NUM_EV-1:0] ien;
        logic [DIV_W-1:0]  reload;
        logic [CNT_W-1:0]  count;
        logic [CNT_W-1:0]  alarm;
    } core_t;

    localparam core_t CORE_RST = '{
        cfg:    1'b0,
        busy:   1'b0,
        sync:   1'b0,
        ien:    '0,
        reload: RST_RELOAD,
        count:  '0,
        alarm:  '0
    };

    core_t st_d, st_q;

    // ---------------- bus decode ----------------
    logic            wr_ctl0, wr_ctl1, is_core, stg_wr;
    logic [IW-1:0]   stg_idx;

    assign wr_ctl0 = bus_wr && (bus_addr == RA_CTL0);
    assign wr_ctl1 = bus_wr && (bus_addr == RA_CTL1);
    assign is_core = (bus_addr >= RA_DIVH);
    assign stg_wr  = bus_wr && is_core && st_q.cfg;
    assign stg_idx = IW'(bus_addr - RA_DIVH);

    // ---------------- staging ----------------
    logic                        commit, step;
    logic [NUM_HALF-1:0][BUS_W-1:0] sv;
    logic [NUM_HALF-1:0]         sp;

    assign commit = st_q.busy && lclk_en;
    assign step   = lclk_en && !commit;

    rtc_stage #(
        .DW (BUS_W),
        .NH (NUM_HALF)
    ) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (dom_rst),
        .wr_en  (stg_wr),
        .wr_idx (stg_idx),
        .wdata  (bus_wdata),
        .apply  (commit),
        .val    (sv),
        .pend   (sp)
    );

    logic [BUS_W-1:DIV_HI_W] unused_stage_hi;
    assign unused_stage_hi = sv[0][BUS_W-1:DIV_HI_W];

    // merged values: only halves written inside the window replace live ones
    logic [DIV_W-1:0] new_reload;
    logic [CNT_W-1:0] new_count, new_alarm;

    always_comb begin
        new_reload = {sp[0] ? sv[0][DIV_HI_W-1:0] : st_q.reload[DIV_W-1:BUS_W],
                      sp[1] ? sv[1]               : st_q.reload[BUS_W-1:0]};
        new_count  = {sp[2] ? sv[2] : st_q.count[CNT_W-1:BUS_W],
                      sp[3] ? sv[3] : st_q.count[BUS_W-1:0]};
        new_alarm  = {sp[4] ? sv[4] : st_q.alarm[CNT_W-1:BUS_W],
                      sp[5] ? sv[5] : st_q.alarm[BUS_W-1:0]};
    end

    // ---------------- divider ----------------
    logic             tick, div_load;
    logic [DIV_W-1:0] div_reload;

    assign div_load   = commit && (sp[0] || sp[1]);
    assign div_reload = commit ? new_reload : st_q.reload;

    rtc_prescaler #(
        .DIV_W      (DIV_W),
        .RST_RELOAD (RST_RELOAD)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (dom_rst),
        .step   (step),
        .load   (div_load),
        .reload (div_reload),
        .tick   (tick)
    );

    // ---------------- events ----------------
    logic [CNT_W-1:0]  cnt_inc;
    logic [NUM_EV-1:0] ev_set, flags_now;

    always_comb begin
        cnt_inc          = st_q.count + 1'b1;
        ev_set           = '0;
        ev_set[EV_TICK]  = tick;
        ev_set[EV_CMP]   = tick && (cnt_inc == st_q.alarm);
        ev_set[EV_WRAP]  = tick && (st_q.count == '1);
    end

    rtc_events #(
        .N (NUM_EV)
    ) u_ev (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dom_rst),
        .set   (ev_set),
        .wr_en (wr_ctl0),
        .wmask (bus_wdata[NUM_EV-1:0]),
        .en    (st_q.ien),
        .flags (flags_now),
        .irq   (irq)
    );

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.busy   = 1'b0;
            st_d.reload = new_reload;
            st_d.count  = new_count;
            st_d.alarm  = new_alarm;
        end else if (tick) begin
            st_d.count  = cnt_inc;
        end
        if (wr_ctl0) begin
            if (st_q.cfg && !bus_wdata[CL_CFG]) begin
                st_d.busy = 1'b1;
            end
            st_d.cfg = bus_wdata[CL_CFG] && !st_q.busy;
            if (!bus_wdata[CL_SYNC]) begin
                st_d.sync = 1'b0;
            end
        end
        if (lclk_en) begin
            st_d.sync = 1'b1;
        end
        if (wr_ctl1) begin
            st_d.ien = bus_wdata[NUM_EV-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CORE_RST;
        end else if (dom_rst) begin
            st_q <= CORE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CTL0: begin
                bus_rdata[NUM_EV-1:0] = flags_now;
                bus_rdata[CL_SYNC]    = st_q.sync;
                bus_rdata[CL_CFG]     = st_q.cfg;
                bus_rdata[CL_DONE]    = !st_q.busy;
            end
            RA_CTL1: bus_rdata[NUM_EV-1:0] = st_q.ien;
            RA_DIVH: bus_rdata = BUS_W'(st_q.reload[DIV_W-1:BUS_W]);
            RA_DIVL: bus_rdata = st_q.reload[BUS_W-1:0];
            RA_CNTH: bus_rdata = st_q.count[CNT_W-1:BUS_W];
            RA_CNTL: bus_rdata = st_q.count[BUS_W-1:0];
            RA_CMPH: bus_rdata = st_q.alarm[CNT_W-1:BUS_W];
            RA_CMPL: bus_rdata = st_q.alarm[BUS_W-1:0];
            default: bus_rdata = '0;
        endcase
    end

    // plain views of the state for the bound checker
    logic              cfg_now, busy_now, sync_now;
    logic [NUM_EV-1:0] ien_now;
    logic [CNT_W-1:0]  count_now, alarm_now;

    assign cfg_now   = st_q.cfg;
    assign busy_now  = st_q.busy;
    assign sync_now  = st_q.sync;
    assign ien_now   = st_q.ien;
    assign count_now = st_q.count;
    assign alarm_now = st_q.alarm;

endmodule

// File: rtl/rtc_counter_core_chk.sv
module rtc_counter_core_chk #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned NUM_EV = 3,
    parameter int unsigned ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dom_rst,
    input logic              lclk_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq,
    input logic              tick,
    input logic              cfg,
    input logic              busy,
    input logic              sync,
    input logic [NUM_EV-1:0] flags,
    input logic [NUM_EV-1:0] ien,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  alarm
);

    // R2: a tick advances the counter by exactly one
    a_r2_tick_advances: assert property (@(posedge clk) disable iff (!rst_n || dom_rst)
        tick |=> (count == $past(count) + 1'b1));

    // R3: the compare value moves only on a commit strobe
    a_r3_alarm_commit_only: assert property (@(posedge clk) disable iff (!rst_n || dom_rst)
        !(busy && lclk_en) |=> $stable(alarm));

    // R5: a pending commit waits for a strobe
    a_r5_busy_until_strobe: assert property (@(posedge clk) disable iff (!rst_n || dom_rst)
        (busy && !lclk_en) |=> busy);

    // R6: no open window while a commit is pending
    a_r6_no_window_while_busy: assert property (@(posedge clk) disable iff (!rst_n || dom_rst)
        busy |-> !cfg);

    // R7: every strobe leaves the refreshed bit set
    a_r7_sync_after_strobe: assert property (@(posedge clk) disable iff (!rst_n || dom_rst)
        lclk_en |=> sync);

    // R10: the wrapping tick raises the wrap flag
    a_r10_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n || dom_rst)
        (tick && (count == '1)) |=> flags[2]);

    // R11: the interrupt holds until software touches a control register
    a_r11_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n || dom_rst)
        (irq && !(bus_wr && (bus_addr <= ADDR_W'(1)))) |=> irq);

    // R13: domain reset clears the domain state
    a_r13_domain_reset: assert property (@(posedge clk) disable iff (!rst_n)
        dom_rst |=> ((count == '0) && (alarm == '0) && (flags == '0) && (ien == '0) && !irq && !busy));

endmodule

bind rtc_counter_core rtc_counter_core_chk #(
    .CNT_W  (32),
    .NUM_EV (3),
    .ADDR_W (3)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dom_rst  (dom_rst),
    .lclk_en  (lclk_en),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .irq      (irq),
    .tick     (tick),
    .cfg      (cfg_now),
    .busy     (busy_now),
    .sync     (sync_now),
    .flags    (flags_now),
    .ien      (ien_now),
    .count    (count_now),
    .alarm    (alarm_now)
);

// File: tb/sim_rtc_counter_core.sv
module sim_rtc_counter_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dom_rst = 1'b0;
    logic        lclk_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit mon_req = 1'b0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;

    rtc_counter_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .dom_rst   (dom_rst),
        .lclk_en   (lclk_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: pops the scoreboard and compares at the falling edge
    always @(negedge clk) begin
        if (mon_req && sb.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = sb.pop_front();
            act = it.is_irq ? {15'd0, irq} : bus_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=0x%04h expected=0x%04h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic strobe(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            lclk_en = 1'b1;
            @(posedge clk); #1;
            lclk_en = 1'b0;
        end
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [15:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb.push_back(it);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.is_irq = 1'b1; it.exp = {15'd0, e}; it.tag = tag;
        sb.push_back(it);
        mon_req = 1'b1;
        @(posedge clk); #1;
        mon_req = 1'b0;
    endtask

    task automatic finish_run();
        if (sb.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard R1 actual=%0d expected=0 items left", sb.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog all actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_rd(3'd0, 16'h0020, "R1 ctl0");
        expect_rd(3'd1, 16'h0000, "R1 ctl1");
        expect_rd(3'd2, 16'h0000, "R1 divh");
        expect_rd(3'd3, 16'h8000, "R1 divl");
        expect_rd(3'd5, 16'h0000, "R1 cntl");
        expect_rd(3'd7, 16'h0000, "R1 cmpl");
        expect_irq(1'b0, "R1 irq");

        // R4 writes outside the window
        wr(3'd5, 16'h1234);
        wr(3'd7, 16'h0005);
        wr(3'd3, 16'h0003);
        expect_rd(3'd5, 16'h0000, "R4 cntl unchanged");
        expect_rd(3'd7, 16'h0000, "R4 cmpl unchanged");
        expect_rd(3'd3, 16'h8000, "R4 divl unchanged");

        // R3 window, staging, commit
        wr(3'd0, 16'h0010);
        expect_rd(3'd0, 16'h0030, "R3 window open");
        wr(3'd3, 16'h0003);
        wr(3'd7, 16'h0002);
        expect_rd(3'd3, 16'h8000, "R3 live reload before commit");
        expect_rd(3'd7, 16'h0000, "R3 live cmp before commit");
        wr(3'd0, 16'h0000);
        expect_rd(3'd0, 16'h0000, "R5 done low after close");
        wr(3'd0, 16'h0010);
        expect_rd(3'd0, 16'h0000, "R6 window refused while busy");
        strobe(1);
        expect_rd(3'd0, 16'h0028, "R5 done after strobe");
        expect_rd(3'd3, 16'h0003, "R3 reload committed");
        expect_rd(3'd7, 16'h0002, "R3 cmp committed");
        expect_rd(3'd5, 16'h0000, "R4 cntl not staged");

        // R2 period equals reload
        strobe(2);
        expect_rd(3'd5, 16'h0000, "R2 no tick before period");
        strobe(1);
        expect_rd(3'd5, 16'h0001, "R2 tick on third strobe");
        expect_rd(3'd0, 16'h0029, "R2 tick flag");
        expect_irq(1'b0, "R11 masked");
        wr(3'd1, 16'h0001);
        expect_rd(3'd1, 16'h0001, "R11 enable readback");
        expect_irq(1'b1, "R11 tick enabled");
        wr(3'd0, 16'h000F);
        expect_rd(3'd0, 16'h0029, "R8 write one keeps");
        wr(3'd0, 16'h000E);
        expect_rd(3'd0, 16'h0028, "R8 write zero clears");
        expect_irq(1'b0, "R11 irq drops");

        // R9 compare
        strobe(3);
        expect_rd(3'd5, 16'h0002, "R9 count at compare");
        expect_rd(3'd0, 16'h002B, "R9 compare flag");
        wr(3'd1, 16'h0002);
        expect_irq(1'b1, "R11 compare enabled");
        wr(3'd0, 16'h000D);
        expect_rd(3'd0, 16'h0029, "R8 compare cleared");
        expect_irq(1'b0, "R11 only masked flag left");

        // R10 wrap
        wr(3'd0, 16'h0018);
        expect_rd(3'd0, 16'h0038, "R3 window open again");
        wr(3'd4, 16'hFFFF);
        wr(3'd5, 16'hFFFF);
        wr(3'd3, 16'h0001);
        wr(3'd0, 16'h0008);
        expect_rd(3'd0, 16'h0008, "R5 busy again");
        strobe(1);
        expect_rd(3'd4, 16'hFFFF, "R3 counter high committed");
        expect_rd(3'd0, 16'h0028, "R3 commit strobe no tick");
        strobe(1);
        expect_rd(3'd4, 16'h0000, "R10 high wraps");
        expect_rd(3'd5, 16'h0000, "R10 low wraps");
        expect_rd(3'd0, 16'h002D, "R10 wrap flag");
        wr(3'd1, 16'h0004);
        expect_irq(1'b1, "R11 wrap enabled");

        // R7 refreshed bit
        wr(3'd0, 16'h0007);
        expect_rd(3'd0, 16'h0025, "R7 cleared by software");
        strobe(1);
        expect_rd(3'd0, 16'h002D, "R7 set by strobe");
        expect_rd(3'd5, 16'h0001, "R2 reload one ticks every strobe");

        // R12 reload width, partial commit
        wr(3'd0, 16'h0018);
        wr(3'd2, 16'hFFFF);
        wr(3'd3, 16'hFFFF);
        wr(3'd0, 16'h0008);
        strobe(1);
        expect_rd(3'd2, 16'h000F, "R12 high part four bits");
        expect_rd(3'd3, 16'hFFFF, "R12 low part");
        expect_rd(3'd5, 16'h0001, "R3 unwritten halves kept");

        // R13 domain reset
        @(posedge clk); #1 dom_rst = 1'b1;
        @(posedge clk); #1 dom_rst = 1'b0;
        expect_rd(3'd0, 16'h0020, "R13 ctl0");
        expect_rd(3'd1, 16'h0000, "R13 ctl1");
        expect_rd(3'd2, 16'h0000, "R13 divh");
        expect_rd(3'd3, 16'h8000, "R13 divl");
        expect_rd(3'd5, 16'h0000, "R13 cntl");
        expect_rd(3'd7, 16'h0000, "R13 cmpl");
        expect_irq(1'b0, "R13 irq");

        repeat (2) @(posedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule